// File: doc/BRIEF.md
# UART Cipher Command Controller

This block sits between a byte-level UART receiver/transmitter pair and a block cipher core made of a key unit and an encryption engine. It reads a stream of received bytes, decodes one-byte opcodes, gathers their payloads and drives the cipher core. The round count and the key length are packed into the upper bits of their opcodes. Key bytes go straight to the key unit. The 128-bit input block is held in a local bank. After each command the block answers with a single status byte, or with the 16-byte ciphertext. The serial line is 8N1 at 115200 baud from a 12 MHz clock, but framing is done outside this block: it sees only whole bytes.

The controller is one finite state machine. `ST_START` is the reset state and moves to `ST_BOOT` unconditionally. `ST_BOOT` offers the ready byte and goes to `ST_IDLE` once it is accepted. `ST_IDLE` decodes each received byte:
- A round opcode goes to `ST_STATUS`.
- A key opcode goes to `ST_KEY_LOAD`, or straight to `ST_KEY_GO` when its length is zero.
- The block opcode goes to `ST_BLK_LOAD`.
- The encrypt opcode goes to `ST_ENC_GO`.
- Any other byte keeps the machine in `ST_IDLE`.

The remaining states move as follows:
- `ST_KEY_LOAD` goes to `ST_KEY_GO` on the last key byte.
- `ST_KEY_GO` lasts one cycle, then moves to `ST_KEY_WAIT`.
- `ST_KEY_WAIT` goes to `ST_STATUS` on key done.
- `ST_BLK_LOAD` goes to `ST_STATUS` on the 16th byte.
- `ST_ENC_GO` lasts one cycle, then moves to `ST_ENC_WAIT`.
- `ST_ENC_WAIT` goes to `ST_ENC_SEND` on encryption done.
- `ST_ENC_SEND` returns to `ST_IDLE` after the 16th byte is accepted.
- `ST_STATUS` returns to `ST_IDLE` once its byte is accepted.

Top module: `cipher_cmd_ctrl`

## Requirements
- R1: After reset is released the block offers the byte 0x45 on the transmit stream exactly once and then sends nothing until a command arrives. While reset is held, tx_valid is 0 and rounds_o is 20.
- R2: A received byte of the form 010rrrrr sets rounds_o to rrrrr in the following cycle and is answered with 0x43. It carries no payload.
- R3: A received byte of the form 10nnnnnn sets key_len_o to nnnnnn. Each of the next n received bytes is passed to the key unit with one key_we cycle, with key_idx counting 0 to n-1 and key_byte equal to the received byte. key_we never rises outside such a payload.
- R4: After the last key byte, or directly after the opcode when n is 0, key_start is high for exactly one cycle. The reply 0x42 is offered only after key_done has been seen.
- R5: Byte 0x00 is followed by 16 payload bytes. Payload byte i (0 to 15) is stored at block_o[8i+7:8i], so A occupies bits 31:0, B 63:32, C 95:64 and D 127:96, each word little-endian. The reply 0x44 follows the 16th byte, and enc_start stays low.
- R6: Byte 0x01 raises enc_start for exactly one cycle. When enc_done is seen, enc_result is captured and sent as 16 bytes, byte i being enc_result[8i+7:8i], with no status byte.
- R7: Bytes received while key expansion or encryption is pending, or while a reply is being sent, are discarded. They change neither rounds_o nor block_o, start no payload and produce no reply.
- R8: Any other opcode (001xxxxx, 011xxxxx, 11xxxxxx, 0x02 to 0x1F) changes nothing and produces no reply. The next received byte is decoded as an opcode.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe per received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_data | output | 8 | Byte to transmit |
| rounds_o | output | 5 | Round count for key unit and engine |
| key_len_o | output | 6 | Announced key length in bytes |
| key_we | output | 1 | Key byte write strobe |
| key_idx | output | 6 | Index of the key byte being written |
| key_byte | output | 8 | Key byte value |
| key_start | output | 1 | One-cycle start of key expansion |
| key_done | input | 1 | Key expansion finished |
| block_o | output | 128 | Stored input block, A in the low word |
| enc_start | output | 1 | One-cycle start of encryption |
| enc_done | input | 1 | Encryption finished, result valid |
| enc_result | input | 128 | Ciphertext, A in the low word |

## Verification
The assertions check, on every cycle, that transmit data holds under back-pressure and that each start strobe lasts a single cycle. They also check that the two start strobes never coincide, that the round count moves only right after a round opcode, and that key writes never overlap a transmission. Only the bench scenarios can show the order and values of the key writes and the byte placement in the stored block. The same holds for the ciphertext byte order, the discarding of bytes during waits, the silence after unknown opcodes, and the single ready byte after each reset.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    localparam int ROUND_W   = 5;
    localparam int KEY_LEN_W = 6;

    localparam logic [7:0] STS_ROUNDS = 8'h43;
    localparam logic [7:0] STS_KEY    = 8'h42;
    localparam logic [7:0] STS_BLOCK  = 8'h44;
    localparam logic [7:0] STS_READY  = 8'h45;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ROUNDS,
        OP_KEY,
        OP_BLOCK,
        OP_ENC
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_START,
        ST_BOOT,
        ST_IDLE,
        ST_KEY_LOAD,
        ST_KEY_GO,
        ST_KEY_WAIT,
        ST_BLK_LOAD,
        ST_ENC_GO,
        ST_ENC_WAIT,
        ST_ENC_SEND,
        ST_STATUS
    } state_e;

endpackage

// File: rtl/ucc_opdecode.sv
module ucc_opdecode
    import ucc_pkg::*;
(
    input  logic [7:0]           op,
    output op_kind_e             kind,
    output logic [ROUND_W-1:0]   op_rounds,
    output logic [KEY_LEN_W-1:0] op_klen
);

    always_comb begin
        kind = OP_NONE;
        if (op[7:6] == 2'b10) begin
            kind = OP_KEY;
        end else if (op[7:5] == 3'b010) begin
            kind = OP_ROUNDS;
        end else if (op == 8'h00) begin
            kind = OP_BLOCK;
        end else if (op == 8'h01) begin
            kind = OP_ENC;
        end
    end

    assign op_rounds = op[ROUND_W-1:0];
    assign op_klen   = op[KEY_LEN_W-1:0];

endmodule

// File: rtl/ucc_bytebank.sv
module ucc_bytebank #(
    parameter int NBYTES = 16,
    localparam int IDXW  = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_byte,
    input  logic                  ld_en,
    input  logic [8*NBYTES-1:0]   ld_word,
    output logic [8*NBYTES-1:0]   word
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 8'h00;
            end else if (ld_en) begin
                q <= ld_word[8*g +: 8];
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                q <= wr_byte;
            end
        end
        assign word[8*g +: 8] = q;
    end

endmodule

// File: rtl/cipher_cmd_ctrl.sv
module cipher_cmd_ctrl
    import ucc_pkg::*;
#(
    parameter int BLK_BYTES  = 16,
    parameter int ROUNDS_RST = 20,
    localparam int BLK_W     = 8 * BLK_BYTES,
    localparam int BIDX      = $clog2(BLK_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_data,
    output logic [ROUND_W-1:0]    rounds_o,
    output logic [KEY_LEN_W-1:0]  key_len_o,
    output logic                  key_we,
    output logic [KEY_LEN_W-1:0]  key_idx,
    output logic [7:0]            key_byte,
    output logic                  key_start,
    input  logic                  key_done,
    output logic [BLK_W-1:0]      block_o,
    output logic                  enc_start,
    input  logic                  enc_done,
    input  logic [BLK_W-1:0]      enc_result
);

    localparam int CNT_W = KEY_LEN_W;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLK_BYTES - 1);

    state_e                 state, state_n;
    op_kind_e               op_kind;
    logic [ROUND_W-1:0]     op_rounds;
    logic [KEY_LEN_W-1:0]   op_klen;
    logic [CNT_W-1:0]       cnt;
    logic [KEY_LEN_W-1:0]   len_q;
    logic [ROUND_W-1:0]     rounds_q;
    logic [7:0]             status_q;
    logic                   blk_wr;
    logic                   res_ld;
    logic [BLK_W-1:0]       res_word;

    ucc_opdecode i_dec (
        .op        (rx_data),
        .kind      (op_kind),
        .op_rounds (op_rounds),
        .op_klen   (op_klen)
    );

    ucc_bytebank #(.NBYTES(BLK_BYTES)) i_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (blk_wr),
        .wr_idx  (cnt[BIDX-1:0]),
        .wr_byte (rx_data),
        .ld_en   (1'b0),
        .ld_word ({BLK_W{1'b0}}),
        .word    (block_o)
    );

    ucc_bytebank #(.NBYTES(BLK_BYTES)) i_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (1'b0),
        .wr_idx  ({BIDX{1'b0}}),
        .wr_byte (8'h00),
        .ld_en   (res_ld),
        .ld_word (enc_result),
        .word    (res_word)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_START: state_n = ST_BOOT;
            ST_BOOT:  if (tx_ready) state_n = ST_IDLE;
            ST_IDLE: begin
                if (rx_valid) begin
                    unique case (op_kind)
                        OP_ROUNDS: state_n = ST_STATUS;
                        OP_KEY:    state_n = (op_klen == '0) ? ST_KEY_GO : ST_KEY_LOAD;
                        OP_BLOCK:  state_n = ST_BLK_LOAD;
                        OP_ENC:    state_n = ST_ENC_GO;
                        default:   state_n = ST_IDLE;
                    endcase
                end
            end
            ST_KEY_LOAD: if (rx_valid && (cnt == len_q - ONE)) state_n = ST_KEY_GO;
            ST_KEY_GO:   state_n = ST_KEY_WAIT;
            ST_KEY_WAIT: if (key_done) state_n = ST_STATUS;
            ST_BLK_LOAD: if (rx_valid && (cnt == BLK_LAST)) state_n = ST_STATUS;
            ST_ENC_GO:   state_n = ST_ENC_WAIT;
            ST_ENC_WAIT: if (enc_done) state_n = ST_ENC_SEND;
            ST_ENC_SEND: if (tx_ready && (cnt == BLK_LAST)) state_n = ST_IDLE;
            ST_STATUS:   if (tx_ready) state_n = ST_IDLE;
            default:     state_n = ST_START;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_START;
        end else begin
            state <= state_n;
        end
    end

    // counters and captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            len_q    <= '0;
            rounds_q <= ROUND_W'(ROUNDS_RST);
            status_q <= STS_READY;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_valid) begin
                        cnt <= '0;
                        if (op_kind == OP_ROUNDS) begin
                            rounds_q <= op_rounds;
                            status_q <= STS_ROUNDS;
                        end
                        if (op_kind == OP_KEY) begin
                            len_q <= op_klen;
                        end
                    end
                end
                ST_KEY_LOAD: if (rx_valid) cnt <= cnt + ONE;
                ST_KEY_WAIT: if (key_done) status_q <= STS_KEY;
                ST_BLK_LOAD: begin
                    if (rx_valid) begin
                        cnt <= cnt + ONE;
                        if (cnt == BLK_LAST) status_q <= STS_BLOCK;
                    end
                end
                ST_ENC_WAIT: cnt <= '0;
                ST_ENC_SEND: if (tx_ready) cnt <= cnt + ONE;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        key_we    = 1'b0;
        key_start = 1'b0;
        enc_start = 1'b0;
        blk_wr    = 1'b0;
        res_ld    = 1'b0;
        unique case (state)
            ST_BOOT: begin
                tx_valid = 1'b1;
                tx_data  = STS_READY;
            end
            ST_STATUS: begin
                tx_valid = 1'b1;
                tx_data  = status_q;
            end
            ST_ENC_SEND: begin
                tx_valid = 1'b1;
                tx_data  = res_word[8*cnt[BIDX-1:0] +: 8];
            end
            ST_KEY_LOAD: key_we    = rx_valid;
            ST_KEY_GO:   key_start = 1'b1;
            ST_BLK_LOAD: blk_wr    = rx_valid;
            ST_ENC_GO:   enc_start = 1'b1;
            ST_ENC_WAIT: res_ld    = enc_done;
            default: ;
        endcase
    end

    assign key_idx   = cnt;
    assign key_byte  = rx_data;
    assign rounds_o  = rounds_q;
    assign key_len_o = len_q;

endmodule

// File: rtl/ucc_checker.sv
module ucc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic [4:0] rounds_o,
    input logic       key_we,
    input logic       key_start,
    input logic       enc_start
);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9

    AST_KEY_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_start |=> !key_start); // R4

    AST_ENC_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |=> !enc_start); // R6

    AST_STARTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_start && enc_start)); // R6

    AST_ROUNDS_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rounds_o) |-> ($past(rx_valid) && ($past(rx_data[7:5]) == 3'b010))); // R2

    AST_KEYWE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |-> !tx_valid); // R3

endmodule

bind cipher_cmd_ctrl ucc_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rounds_o  (rounds_o),
    .key_we    (key_we),
    .key_start (key_start),
    .enc_start (enc_start)
);

// File: tb/test_cipher_cmd_ctrl.sv
module test_cipher_cmd_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = 8'h00;
    logic         tx_valid;
    logic         tx_ready = 1'b1;
    logic [7:0]   tx_data;
    logic [4:0]   rounds_o;
    logic [5:0]   key_len_o;
    logic         key_we;
    logic [5:0]   key_idx;
    logic [7:0]   key_byte;
    logic         key_start;
    logic         key_done = 1'b0;
    logic [127:0] block_o;
    logic         enc_start;
    logic         enc_done = 1'b0;
    logic [127:0] enc_result = 128'h0;

    localparam logic [127:0] RES = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

    // {opcode, reply expected, rounds expected afterwards}
    localparam logic [23:0] VEC [7] = '{
        24'h4C_01_0C,
        24'h5F_01_1F,
        24'h40_01_00,
        24'h60_00_00,
        24'hC5_00_00,
        24'h22_00_00,
        24'h47_01_07
    };

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int kcnt = 0, ecnt = 0;
    int key_starts = 0, enc_starts = 0, kwe_cnt = 0;
    bit key_done_seen = 0;
    logic [5:0] kidx_log [8];
    logic [7:0] kbyte_log [8];

    cipher_cmd_ctrl i_cipher_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rounds_o(rounds_o), .key_len_o(key_len_o), .key_we(key_we),
        .key_idx(key_idx), .key_byte(key_byte), .key_start(key_start),
        .key_done(key_done), .block_o(block_o), .enc_start(enc_start),
        .enc_done(enc_done), .enc_result(enc_result)
    );

    always #2.5 clk = ~clk;

    // key unit and engine models, sampling at the falling edge
    always @(negedge clk) begin
        key_done = 1'b0;
        enc_done = 1'b0;
        if (kcnt != 0) begin
            kcnt--;
            if (kcnt == 0) begin
                key_done = 1'b1;
                key_done_seen = 1;
            end
        end
        if (ecnt != 0) begin
            ecnt--;
            if (ecnt == 0) begin
                enc_done = 1'b1;
                enc_result = RES;
            end
        end
        if (key_start) begin
            key_starts++;
            kcnt = 6;
        end
        if (enc_start) begin
            enc_starts++;
            ecnt = 5;
        end
        if (key_we) begin
            if (kwe_cnt < 8) begin
                kidx_log[kwe_cnt]  = key_idx;
                kbyte_log[kwe_cnt] = key_byte;
            end
            kwe_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, output bit ok);
        ok = 0;
        b  = 8'h00;
        for (int i = 0; i < 200; i++) begin
            if (tx_valid) begin
                b  = tx_data;
                ok = 1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_byte(input logic [7:0] exp, input string tag);
        logic [7:0] b;
        bit ok;
        get_byte(b, ok);
        check(ok && (b == exp), tag, {120'h0, b}, {120'h0, exp});
    endtask

    task automatic expect_silence(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        check(seen == 0, tag, 128'(seen), 128'h0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [127:0] exp_blk;
        logic [7:0] b;
        bit ok;

        // reset state
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0, "R1 tx idle in reset", {127'h0, tx_valid}, 128'h0);
        check(rounds_o == 5'd20, "R1 rounds reset value", {123'h0, rounds_o}, 128'd20);
        rst_n = 1'b1;
        expect_byte(8'h45, "R1 ready byte");
        expect_silence(10, "R1 ready sent once");

        // table of round and unknown opcodes
        for (int v = 0; v < 7; v++) begin
            send_byte(VEC[v][23:16]);
            if (VEC[v][8]) begin
                expect_byte(8'h43, "R2 round reply");
            end else begin
                expect_silence(6, "R8 no reply to unknown opcode");
            end
            check(rounds_o == VEC[v][4:0], "R2/R8 rounds value",
                  {123'h0, rounds_o}, {123'h0, VEC[v][4:0]});
        end

        // key of three bytes, with a discarded byte during expansion
        kwe_cnt = 0; key_starts = 0; key_done_seen = 0;
        send_byte(8'h83);
        check(key_len_o == 6'd3, "R3 key length", {122'h0, key_len_o}, 128'd3);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'hA7);
        send_byte(8'h4A);
        get_byte(b, ok);
        check(ok && (b == 8'h42), "R4 key reply", {120'h0, b}, 128'h42);
        check(key_done_seen, "R4 reply after key done", {127'h0, key_done_seen}, 128'h1);
        check(key_starts == 1, "R4 single key start", 128'(key_starts), 128'h1);
        check(kwe_cnt == 3, "R3 key write count", 128'(kwe_cnt), 128'd3);
        check(kidx_log[0] == 6'd0 && kbyte_log[0] == 8'h11, "R3 key byte 0",
              {kidx_log[0], kbyte_log[0]}, {6'd0, 8'h11});
        check(kidx_log[1] == 6'd1 && kbyte_log[1] == 8'h22, "R3 key byte 1",
              {kidx_log[1], kbyte_log[1]}, {6'd1, 8'h22});
        check(kidx_log[2] == 6'd2 && kbyte_log[2] == 8'hA7, "R3 key byte 2",
              {kidx_log[2], kbyte_log[2]}, {6'd2, 8'hA7});
        check(rounds_o == 5'd7, "R7 byte during expansion discarded",
              {123'h0, rounds_o}, 128'd7);
        expect_silence(6, "R7 no reply to discarded byte");

        // zero-length key
        kwe_cnt = 0; key_starts = 0;
        send_byte(8'h80);
        expect_byte(8'h42, "R4 empty key reply");
        check(key_starts == 1 && kwe_cnt == 0, "R4 empty key starts without writes",
              128'(key_starts * 16 + kwe_cnt), 128'h10);

        // block load
        kwe_cnt = 0; enc_starts = 0;
        exp_blk = '0;
        send_byte(8'h00);
        for (int i = 0; i < 16; i++) begin
            b = 8'h3C ^ 8'(i * 17);
            exp_blk[8*i +: 8] = b;
            send_byte(b);
            if (i == 14) expect_silence(3, "R5 no reply before 16th byte");
        end
        expect_byte(8'h44, "R5 block reply");
        check(block_o == exp_blk, "R5 block byte placement", block_o, exp_blk);
        check(enc_starts == 0, "R5 no encryption on load", 128'(enc_starts), 128'h0);
        check(kwe_cnt == 0, "R3 no key writes outside key payload", 128'(kwe_cnt), 128'h0);

        // encryption, with a discarded block opcode during the wait
        send_byte(8'h01);
        send_byte(8'h00);
        for (int i = 0; i < 16; i++) begin
            expect_byte(RES[8*i +: 8], "R6 ciphertext byte");
        end
        check(enc_starts == 1, "R6 single encrypt start", 128'(enc_starts), 128'h1);
        expect_silence(6, "R6 no status after ciphertext");
        send_byte(8'h41);
        expect_byte(8'h43, "R7 idle after discarded byte");
        check(block_o == exp_blk, "R7 block kept", block_o, exp_blk);

        // back-pressure on the transmit stream
        tx_ready = 1'b0;
        send_byte(8'h45);
        begin
            int bad = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!(tx_valid && tx_data == 8'h43)) bad++;
            end
            check(bad == 0, "R9 byte held while not ready", 128'(bad), 128'h0);
        end
        tx_ready = 1'b1;
        expect_byte(8'h43, "R9 held byte delivered");
        check(rounds_o == 5'd5, "R2 rounds after held reply", {123'h0, rounds_o}, 128'd5);

        // reset in the middle of a block payload
        send_byte(8'h00);
        send_byte(8'h9A);
        send_byte(8'h9B);
        do_reset();
        check(tx_valid == 1'b0 && block_o == 128'h0, "R1 reset clears mid-payload",
              {tx_valid, block_o[126:0]}, 128'h0);
        check(rounds_o == 5'd20, "R1 rounds back to reset value", {123'h0, rounds_o}, 128'd20);
        rst_n = 1'b1;
        expect_byte(8'h45, "R1 ready byte after second reset");
        send_byte(8'h43);
        expect_byte(8'h43, "R2 opcode decoded after reset");
        check(rounds_o == 5'd3, "R2 rounds after reset", {123'h0, rounds_o}, 128'd3);

        finish_run();
    end

endmodule